// File: doc/BRIEF.md
# Exception Priority Resolver

This block sits beside the pipeline control of a small in-order RISC core and decides which one of many pending exception conditions the core takes next. It accepts requests from four groups: asynchronous interrupt requests (hard/power-on reset, machine-check error sources, soft reset, system management, external interrupt, performance monitor, decrementer, thermal), a fetch-stage storage fault, dispatch/execute-stage faults, and a post-execution trace condition. For the winner it reports a one-hot selection, an encoded identifier, the reason code for a program exception, and data-storage status bits.

Asynchronous requests are first caught in a sticky pending register. They stay there until the core acknowledges the exception that consumed them. Maskable requests (system management, external, performance monitor, decrementer, thermal) are taken only while the external-enable input is high. Synchronous faults are level inputs that the core holds until it acknowledges.

A three-state controller sequences each decision. `ST_IDLE` evaluates the requests every cycle and moves to `ST_TAKE` when any eligible request exists; otherwise it stays in `ST_IDLE`. `ST_TAKE` presents the registered result with `take_o` high for exactly one cycle and always moves to `ST_WAIT`. `ST_WAIT` holds off any new decision until `ack_i` is high, then returns to `ST_IDLE` and clears the pending bits of the asynchronous source just taken.

Top module: `exc_prio_resolver`

The identifier `id_o` is also the priority rank, where 0 is the highest:

| id | exception |
|----|-----------|
| 0 | hard reset |
| 1 | machine check |
| 2 | soft reset |
| 3 | fetch fault |
| 4 | instruction address breakpoint |
| 5 | program |
| 6 | system call |
| 7 | FP unavailable |
| 8 | FP enabled |
| 9 | external-access data fault |
| 10 | alignment |
| 11 | block-translation protection |
| 12 | segment-type fault |
| 13 | TLB protection |
| 14 | data address breakpoint |
| 15 | system management |
| 16 | external |
| 17 | performance monitor |
| 18 | decrementer |
| 19 | thermal |
| 20 | trace |

## Requirements
- R1: After reset, `take_o` is 0, and `sel_o`, `id_o`, `prog_why_o` and `ds_status_o` are all zero. The pending register is also empty, so nothing is taken until a new request arrives.
- R2: Among the asynchronous sources the order is hard reset (id 0), then machine check (1), then soft reset (2). The maskable sources follow in this order: system management (15), external (16), performance monitor (17), decrementer (18), thermal (19).
- R3: Machine check (id 1) is requested when any bit of `mc_src_i` is 1.
- R4: Class precedence is as follows. Reset and machine check come first, then the fetch fault (id 3), then the dispatch/execute faults (ids 4 to 14), then the enabled maskable interrupts, then trace (id 20).
- R5: The dispatch/execute order, highest first, is: breakpoint 4, program 5, system call 6, FP unavailable 7, FP enabled 8, external-access fault 9, alignment 10, block protection 11, segment fault 12, TLB protection 13, data breakpoint 14.
- R6: When id 5 is taken, `prog_why_o` carries `prog_why_i` (1 illegal, 2 privileged, 3 trap). For any other exception it is 0.
- R7: Alignment (id 10) is requested when any bit of `align_src_i` is 1. The segment fault (id 12) is requested when either bit of `seg_src_i` is 1: bit 0 for a non-cache access to a T=1 segment, bit 1 for a T=0 to T=1 crossing.
- R8: When a data-storage exception (id 9, 11, 12, 13 or 14) is taken, `ds_status_o` bit 11 equals the external-access fault input and bit 5 equals the segment-fault condition. Both bits may be 1 at once. For any other exception `ds_status_o` is zero.
- R9: Trace (id 20) is requested when `step_en_i` is 1, or when both `brtrace_en_i` and `is_branch_i` are 1.
- R10: Maskable requests are ignored while `ee_i` is 0 but remain pending. They are taken on the first evaluation after `ee_i` becomes 1.
- R11: `take_o` is a one-cycle pulse. While it is high, `sel_o` has exactly one bit set, at position `id_o`. While it is low, `sel_o`, `prog_why_o` and `ds_status_o` are zero.
- R12: After a take, no further take occurs until `ack_i` is seen in `ST_WAIT`. That acknowledge clears the pending bit of the asynchronous source just taken; other pending bits persist.
- R13: A synchronous request present before clock edge k is reported after edge k. An asynchronous request present only before edge k is latched at k and reported after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| ee_i | input | 1 | External-enable gate for maskable interrupts |
| hard_rst_req_i | input | 1 | Hard or power-on reset request |
| mc_src_i | input | MC_W | Machine-check error sources |
| soft_rst_req_i | input | 1 | Soft reset request |
| sysmgmt_i | input | 1 | System management interrupt request |
| extint_i | input | 1 | External interrupt request |
| perfmon_i | input | 1 | Performance-monitor interrupt request |
| decr_i | input | 1 | Decrementer interrupt request |
| thermal_i | input | 1 | Thermal-management interrupt request |
| fetch_fault_i | input | 1 | Fetch-stage instruction storage fault |
| iaddr_bkpt_i | input | 1 | Instruction address breakpoint |
| prog_i | input | 1 | Program exception (illegal, privileged, trap) |
| prog_why_i | input | 2 | Program reason: 1 illegal, 2 privileged, 3 trap |
| syscall_i | input | 1 | System call |
| fp_unavail_i | input | 1 | Floating-point unavailable |
| fp_enabled_i | input | 1 | Floating-point enabled program condition |
| ext_acc_dis_i | input | 1 | External-access instruction while access is disabled |
| align_src_i | input | ALIGN_W | Alignment fault sources |
| blk_prot_i | input | 1 | Block-translation protection fault |
| seg_src_i | input | 2 | Segment-type fault sources |
| tlb_prot_i | input | 1 | TLB protection fault |
| daddr_bkpt_i | input | 1 | Data address breakpoint match |
| step_en_i | input | 1 | Single-step trace enabled |
| brtrace_en_i | input | 1 | Branch trace enabled |
| is_branch_i | input | 1 | Completed instruction is a branch |
| ack_i | input | 1 | Core acknowledges the taken exception |
| take_o | output | 1 | One-cycle strobe: result valid |
| sel_o | output | 21 | One-hot selected exception |
| id_o | output | 5 | Encoded exception id (rank) |
| prog_why_o | output | 2 | Program exception reason |
| ds_status_o | output | DS_W | Data-storage status bits (5 and 11 used) |

## Verification
A synchronous fault is reported one edge after it is applied, because only the result registers lie in its path. An asynchronous request is reported two edges after it is applied, because it first passes through the pending register. The bench therefore applies asynchronous requests one cycle ahead of the synchronous faults of the same vector, so that both meet in the same evaluation edge. It drives inputs on falling edges and samples on the falling edge that follows the evaluation edge. The directed tests count edges explicitly: they check that `take_o` is still low after the first edge of an asynchronous request, and that a held fault is taken exactly two edges after an acknowledge.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int N_EXC   = 21;
    localparam int ID_W    = $clog2(N_EXC);
    localparam int N_ASYNC = 8;

    // exception ids double as priority rank (0 = highest)
    localparam int EX_HARD_RST = 0;
    localparam int EX_MCHK     = 1;
    localparam int EX_SOFT_RST = 2;
    localparam int EX_FETCH    = 3;
    localparam int EX_IBKPT    = 4;
    localparam int EX_PROG     = 5;
    localparam int EX_SYSCALL  = 6;
    localparam int EX_FPUNAV   = 7;
    localparam int EX_FPENA    = 8;
    localparam int EX_DS_EXTAC = 9;
    localparam int EX_ALIGN    = 10;
    localparam int EX_DS_BLK   = 11;
    localparam int EX_DS_SEG   = 12;
    localparam int EX_DS_TLB   = 13;
    localparam int EX_DS_DBKPT = 14;
    localparam int EX_SYSMGMT  = 15;
    localparam int EX_EXTINT   = 16;
    localparam int EX_PERFMON  = 17;
    localparam int EX_DECR     = 18;
    localparam int EX_THERMAL  = 19;
    localparam int EX_TRACE    = 20;

    // positions inside the pending register
    localparam int PD_HARD_RST = 0;
    localparam int PD_MCHK     = 1;
    localparam int PD_SOFT_RST = 2;
    localparam int PD_SYSMGMT  = 3;
    localparam int PD_EXTINT   = 4;
    localparam int PD_PERFMON  = 5;
    localparam int PD_DECR     = 6;
    localparam int PD_THERMAL  = 7;

    // data-storage status bit positions decoded by the handler
    localparam int DS_BIT_SEG   = 5;
    localparam int DS_BIT_EXTAC = 11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TAKE,
        ST_WAIT
    } res_state_e;

    // which pending bit an exception id consumes on acknowledge
    function automatic logic [N_ASYNC-1:0] pend_mask_of(input logic [ID_W-1:0] id);
        logic [N_ASYNC-1:0] m;
        m = '0;
        unique case (int'(id))
            EX_HARD_RST: m[PD_HARD_RST] = 1'b1;
            EX_MCHK:     m[PD_MCHK]     = 1'b1;
            EX_SOFT_RST: m[PD_SOFT_RST] = 1'b1;
            EX_SYSMGMT:  m[PD_SYSMGMT]  = 1'b1;
            EX_EXTINT:   m[PD_EXTINT]   = 1'b1;
            EX_PERFMON:  m[PD_PERFMON]  = 1'b1;
            EX_DECR:     m[PD_DECR]     = 1'b1;
            EX_THERMAL:  m[PD_THERMAL]  = 1'b1;
            default:     m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/exc_async_pend.sv
module exc_async_pend #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // a request is captured on the next edge
        assert_pend_capture_R12: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_o[g]);
        // a pending bit is only lost through an acknowledge clear
        assert_pend_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[g] && !clr_i[g]) |=> pend_o[g]);
    end

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int N  = 21,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    // lowest index wins: scan downward so the last hit is the winner
    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o    = '0;
                gnt_o[i] = 1'b1;
                idx_o    = IW'(i);
            end
        end
        any_o = |req_i;
    end

endmodule

// File: rtl/exc_prio_resolver.sv
module exc_prio_resolver
    import exc_pkg::*;
#(
    parameter int MC_W    = 4,
    parameter int ALIGN_W = 6,
    parameter int DS_W    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ee_i,
    input  logic               hard_rst_req_i,
    input  logic [MC_W-1:0]    mc_src_i,
    input  logic               soft_rst_req_i,
    input  logic               sysmgmt_i,
    input  logic               extint_i,
    input  logic               perfmon_i,
    input  logic               decr_i,
    input  logic               thermal_i,
    input  logic               fetch_fault_i,
    input  logic               iaddr_bkpt_i,
    input  logic               prog_i,
    input  logic [1:0]         prog_why_i,
    input  logic               syscall_i,
    input  logic               fp_unavail_i,
    input  logic               fp_enabled_i,
    input  logic               ext_acc_dis_i,
    input  logic [ALIGN_W-1:0] align_src_i,
    input  logic               blk_prot_i,
    input  logic [1:0]         seg_src_i,
    input  logic               tlb_prot_i,
    input  logic               daddr_bkpt_i,
    input  logic               step_en_i,
    input  logic               brtrace_en_i,
    input  logic               is_branch_i,
    input  logic               ack_i,
    output logic               take_o,
    output logic [N_EXC-1:0]   sel_o,
    output logic [ID_W-1:0]    id_o,
    output logic [1:0]         prog_why_o,
    output logic [DS_W-1:0]    ds_status_o
);

    res_state_e state_q, state_d;

    logic [N_ASYNC-1:0] pend, pend_set, pend_clr;
    logic [N_EXC-1:0]   req, gnt;
    logic [ID_W-1:0]    idx;
    logic               any_req;
    logic               seg_any, trace_req, ds_kind;
    logic [DS_W-1:0]    ds_now;

    logic [N_EXC-1:0]   sel_q;
    logic [ID_W-1:0]    id_q;
    logic [1:0]         why_q;
    logic [DS_W-1:0]    ds_q;

    // ---------------- pending latch for asynchronous requests
    always_comb begin
        pend_set              = '0;
        pend_set[PD_HARD_RST] = hard_rst_req_i;
        pend_set[PD_MCHK]     = |mc_src_i;
        pend_set[PD_SOFT_RST] = soft_rst_req_i;
        pend_set[PD_SYSMGMT]  = sysmgmt_i;
        pend_set[PD_EXTINT]   = extint_i;
        pend_set[PD_PERFMON]  = perfmon_i;
        pend_set[PD_DECR]     = decr_i;
        pend_set[PD_THERMAL]  = thermal_i;
    end

    assign pend_clr = (state_q == ST_WAIT && ack_i) ? pend_mask_of(id_q) : '0;

    exc_async_pend #(.N(N_ASYNC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pend_set),
        .clr_i  (pend_clr),
        .pend_o (pend)
    );

    // ---------------- request vector in rank order
    assign seg_any   = |seg_src_i;
    assign trace_req = step_en_i | (brtrace_en_i & is_branch_i);

    always_comb begin
        req              = '0;
        req[EX_HARD_RST] = pend[PD_HARD_RST];
        req[EX_MCHK]     = pend[PD_MCHK];
        req[EX_SOFT_RST] = pend[PD_SOFT_RST];
        req[EX_FETCH]    = fetch_fault_i;
        req[EX_IBKPT]    = iaddr_bkpt_i;
        req[EX_PROG]     = prog_i;
        req[EX_SYSCALL]  = syscall_i;
        req[EX_FPUNAV]   = fp_unavail_i;
        req[EX_FPENA]    = fp_enabled_i;
        req[EX_DS_EXTAC] = ext_acc_dis_i;
        req[EX_ALIGN]    = |align_src_i;
        req[EX_DS_BLK]   = blk_prot_i;
        req[EX_DS_SEG]   = seg_any;
        req[EX_DS_TLB]   = tlb_prot_i;
        req[EX_DS_DBKPT] = daddr_bkpt_i;
        req[EX_SYSMGMT]  = pend[PD_SYSMGMT] & ee_i;
        req[EX_EXTINT]   = pend[PD_EXTINT]  & ee_i;
        req[EX_PERFMON]  = pend[PD_PERFMON] & ee_i;
        req[EX_DECR]     = pend[PD_DECR]    & ee_i;
        req[EX_THERMAL]  = pend[PD_THERMAL] & ee_i;
        req[EX_TRACE]    = trace_req;
    end

    exc_prio_pick #(.N(N_EXC), .IW(ID_W)) u_pick (
        .req_i (req),
        .gnt_o (gnt),
        .idx_o (idx),
        .any_o (any_req)
    );

    assign ds_kind = gnt[EX_DS_EXTAC] | gnt[EX_DS_BLK] | gnt[EX_DS_SEG]
                   | gnt[EX_DS_TLB]   | gnt[EX_DS_DBKPT];

    always_comb begin
        ds_now               = '0;
        ds_now[DS_BIT_EXTAC] = ext_acc_dis_i;
        ds_now[DS_BIT_SEG]   = seg_any;
    end

    // ---------------- state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_req) state_d = ST_TAKE;
            ST_TAKE: state_d = ST_WAIT;
            ST_WAIT: if (ack_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
            why_q <= '0;
            ds_q  <= '0;
        end else if (state_q == ST_IDLE && any_req) begin
            sel_q <= gnt;
            id_q  <= idx;
            why_q <= gnt[EX_PROG] ? prog_why_i : 2'd0;
            ds_q  <= ds_kind ? ds_now : '0;
        end
    end

    // ---------------- outputs
    always_comb begin
        take_o      = (state_q == ST_TAKE);
        sel_o       = take_o ? sel_q : '0;
        id_o        = take_o ? id_q  : '0;
        prog_why_o  = take_o ? why_q : 2'd0;
        ds_status_o = take_o ? ds_q  : '0;
    end

    // ---------------- assertions
    assert_take_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($countones(sel_o) == 1 && sel_o == (N_EXC'(1) << id_o)));

    assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (sel_o == '0 && ds_status_o == '0 && prog_why_o == 2'd0));

    assert_why_only_prog_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && int'(id_o) != EX_PROG) |-> prog_why_o == 2'd0);

    assert_ds_only_storage_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && int'(id_o) != EX_DS_EXTAC && int'(id_o) != EX_DS_BLK &&
         int'(id_o) != EX_DS_SEG && int'(id_o) != EX_DS_TLB &&
         int'(id_o) != EX_DS_DBKPT) |-> ds_status_o == '0);

    assert_mask_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && int'(id_o) >= EX_SYSMGMT && int'(id_o) <= EX_THERMAL) |-> $past(ee_i));

    assert_no_retake_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !ack_i) |=> !take_o);

endmodule

// File: tb/tb_exc_prio_resolver.sv
module tb_exc_prio_resolver;

    localparam int MC_W    = 4;
    localparam int ALIGN_W = 6;
    localparam int DS_W    = 32;
    localparam int NX      = 21;
    localparam logic [4:0] NONE = 5'd31;

    // async request bits
    localparam logic [7:0] A_HRST = 8'h01, A_MC = 8'h02, A_SRST = 8'h04, A_SMI = 8'h08,
                           A_EXT = 8'h10, A_PMON = 8'h20, A_DEC = 8'h40, A_THERM = 8'h80;
    // sync request bits
    localparam logic [12:0] S_ISF = 13'h0001, S_IABR = 13'h0002, S_PROG = 13'h0004,
                            S_SC = 13'h0008, S_FPUN = 13'h0010, S_FPEN = 13'h0020,
                            S_EACC = 13'h0040, S_ALIGN = 13'h0080, S_BAT = 13'h0100,
                            S_SEG = 13'h0200, S_TLB = 13'h0400, S_DAB = 13'h0800,
                            S_STEP = 13'h1000, S_ALL = 13'h1FFF;

    typedef struct packed {
        logic        ee;
        logic [7:0]  as;
        logic [12:0] sy;
        logic [1:0]  why;
        logic [4:0]  eid;
        logic [1:0]  ewhy;
        logic        d11;
        logic        d5;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t TBL [NV] = '{
        '{1'b0, A_HRST|A_MC,   S_ALL,                2'd1, 5'd0,  2'd0, 1'b0, 1'b0},
        '{1'b0, A_MC|A_SRST,   S_ISF,                2'd0, 5'd1,  2'd0, 1'b0, 1'b0},
        '{1'b0, A_SRST|A_SMI,  S_ISF,                2'd0, 5'd2,  2'd0, 1'b0, 1'b0},
        '{1'b0, 8'h00,         S_ISF|S_IABR|S_PROG,  2'd1, 5'd3,  2'd0, 1'b0, 1'b0},
        '{1'b0, 8'h00,         S_IABR|S_PROG|S_STEP, 2'd1, 5'd4,  2'd0, 1'b0, 1'b0},
        '{1'b0, 8'h00,         S_PROG|S_SC,          2'd2, 5'd5,  2'd2, 1'b0, 1'b0},
        '{1'b0, 8'h00,         S_PROG,               2'd1, 5'd5,  2'd1, 1'b0, 1'b0},
        '{1'b0, 8'h00,         S_PROG,               2'd3, 5'd5,  2'd3, 1'b0, 1'b0},
        '{1'b0, 8'h00,         S_SC|S_FPUN,          2'd1, 5'd6,  2'd0, 1'b0, 1'b0},
        '{1'b0, 8'h00,         S_FPUN|S_FPEN,        2'd0, 5'd7,  2'd0, 1'b0, 1'b0},
        '{1'b0, 8'h00,         S_FPEN|S_EACC,        2'd0, 5'd8,  2'd0, 1'b0, 1'b0},
        '{1'b0, 8'h00,         S_EACC|S_ALIGN|S_SEG, 2'd0, 5'd9,  2'd0, 1'b1, 1'b1},
        '{1'b0, 8'h00,         S_EACC,               2'd0, 5'd9,  2'd0, 1'b1, 1'b0},
        '{1'b0, 8'h00,         S_ALIGN|S_BAT|S_SEG,  2'd0, 5'd10, 2'd0, 1'b0, 1'b0},
        '{1'b0, 8'h00,         S_BAT|S_SEG,          2'd0, 5'd11, 2'd0, 1'b0, 1'b1},
        '{1'b0, 8'h00,         S_SEG|S_TLB,          2'd0, 5'd12, 2'd0, 1'b0, 1'b1},
        '{1'b0, 8'h00,         S_TLB|S_DAB,          2'd0, 5'd13, 2'd0, 1'b0, 1'b0},
        '{1'b0, 8'h00,         S_DAB,                2'd0, 5'd14, 2'd0, 1'b0, 1'b0},
        '{1'b1, A_SMI|A_EXT|A_DEC, S_STEP,           2'd0, 5'd15, 2'd0, 1'b0, 1'b0},
        '{1'b1, A_EXT|A_PMON,  13'h0,                2'd0, 5'd16, 2'd0, 1'b0, 1'b0},
        '{1'b1, A_EXT,         S_DAB,                2'd0, 5'd14, 2'd0, 1'b0, 1'b0},
        '{1'b1, A_PMON|A_DEC,  S_STEP,               2'd0, 5'd17, 2'd0, 1'b0, 1'b0},
        '{1'b1, A_DEC|A_THERM, 13'h0,                2'd0, 5'd18, 2'd0, 1'b0, 1'b0},
        '{1'b1, A_THERM,       S_STEP,               2'd0, 5'd19, 2'd0, 1'b0, 1'b0},
        '{1'b0, A_EXT|A_THERM, S_STEP,               2'd0, 5'd20, 2'd0, 1'b0, 1'b0},
        '{1'b0, A_SMI,         13'h0,                2'd0, NONE,  2'd0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ee_i = 1'b0;
    logic hard_rst_req_i = 1'b0, soft_rst_req_i = 1'b0;
    logic [MC_W-1:0] mc_src_i = '0;
    logic sysmgmt_i = 1'b0, extint_i = 1'b0, perfmon_i = 1'b0, decr_i = 1'b0, thermal_i = 1'b0;
    logic fetch_fault_i = 1'b0, iaddr_bkpt_i = 1'b0, prog_i = 1'b0, syscall_i = 1'b0;
    logic [1:0] prog_why_i = 2'd0;
    logic fp_unavail_i = 1'b0, fp_enabled_i = 1'b0, ext_acc_dis_i = 1'b0;
    logic [ALIGN_W-1:0] align_src_i = '0;
    logic blk_prot_i = 1'b0, tlb_prot_i = 1'b0, daddr_bkpt_i = 1'b0;
    logic [1:0] seg_src_i = 2'b00;
    logic step_en_i = 1'b0, brtrace_en_i = 1'b0, is_branch_i = 1'b0, ack_i = 1'b0;
    logic take_o;
    logic [NX-1:0] sel_o;
    logic [4:0] id_o;
    logic [1:0] prog_why_o;
    logic [DS_W-1:0] ds_status_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    exc_prio_resolver #(.MC_W(MC_W), .ALIGN_W(ALIGN_W), .DS_W(DS_W)) dut (
        .clk(clk), .rst_n(rst_n), .ee_i(ee_i),
        .hard_rst_req_i(hard_rst_req_i), .mc_src_i(mc_src_i), .soft_rst_req_i(soft_rst_req_i),
        .sysmgmt_i(sysmgmt_i), .extint_i(extint_i), .perfmon_i(perfmon_i),
        .decr_i(decr_i), .thermal_i(thermal_i), .fetch_fault_i(fetch_fault_i),
        .iaddr_bkpt_i(iaddr_bkpt_i), .prog_i(prog_i), .prog_why_i(prog_why_i),
        .syscall_i(syscall_i), .fp_unavail_i(fp_unavail_i), .fp_enabled_i(fp_enabled_i),
        .ext_acc_dis_i(ext_acc_dis_i), .align_src_i(align_src_i), .blk_prot_i(blk_prot_i),
        .seg_src_i(seg_src_i), .tlb_prot_i(tlb_prot_i), .daddr_bkpt_i(daddr_bkpt_i),
        .step_en_i(step_en_i), .brtrace_en_i(brtrace_en_i), .is_branch_i(is_branch_i),
        .ack_i(ack_i), .take_o(take_o), .sel_o(sel_o), .id_o(id_o),
        .prog_why_o(prog_why_o), .ds_status_o(ds_status_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive_async(input logic [7:0] a);
        hard_rst_req_i = a[0];
        mc_src_i       = a[1] ? MC_W'(1) : '0;
        soft_rst_req_i = a[2];
        sysmgmt_i      = a[3];
        extint_i       = a[4];
        perfmon_i      = a[5];
        decr_i         = a[6];
        thermal_i      = a[7];
    endtask

    task automatic drive_sync(input logic [12:0] s, input logic [1:0] why);
        fetch_fault_i = s[0];
        iaddr_bkpt_i  = s[1];
        prog_i        = s[2];
        prog_why_i    = why;
        syscall_i     = s[3];
        fp_unavail_i  = s[4];
        fp_enabled_i  = s[5];
        ext_acc_dis_i = s[6];
        align_src_i   = s[7] ? ALIGN_W'(1) : '0;
        blk_prot_i    = s[8];
        seg_src_i     = {s[9], 1'b0};
        tlb_prot_i    = s[10];
        daddr_bkpt_i  = s[11];
        step_en_i     = s[12];
    endtask

    // quiet all inputs, enable and hold ack so that every leftover request drains
    task automatic drain();
        drive_async(8'h00);
        drive_sync(13'h0, 2'd0);
        brtrace_en_i = 1'b0;
        is_branch_i  = 1'b0;
        ee_i  = 1'b1;
        ack_i = 1'b1;
        repeat (40) @(negedge clk);
        ack_i = 1'b0;
        ee_i  = 1'b0;
        @(negedge clk);
    endtask

    function automatic string id_tag(input logic [4:0] e);
        if (e <= 5'd2 || (e >= 5'd15 && e <= 5'd19)) return "R2";
        if (e == 5'd3) return "R4";
        if (e <= 5'd14) return "R5";
        if (e == 5'd20) return "R9";
        return "R10";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 take", 32'(take_o), 0);
        chk("R1 sel", 32'(sel_o), 0);
        chk("R1 id", 32'(id_o), 0);
        chk("R1 why", 32'(prog_why_o), 0);
        chk("R1 ds", ds_status_o, 0);

        // table walk: async one cycle ahead, sync at the evaluation edge
        for (int i = 0; i < NV; i++) begin
            ee_i = TBL[i].ee;
            drive_async(TBL[i].as);
            @(negedge clk);
            drive_async(8'h00);
            drive_sync(TBL[i].sy, TBL[i].why);
            @(negedge clk);
            if (TBL[i].eid == NONE) begin
                chk("R10 masked take", 32'(take_o), 0);
            end else begin
                chk({id_tag(TBL[i].eid), " take"}, 32'(take_o), 1);
                chk({id_tag(TBL[i].eid), " id"}, 32'(id_o), 32'(TBL[i].eid));
                chk("R11 sel", 32'(sel_o), 32'(NX'(1) << TBL[i].eid));
                chk("R6 why", 32'(prog_why_o), 32'(TBL[i].ewhy));
                chk("R8 ds bit11", 32'(ds_status_o[11]), 32'(TBL[i].d11));
                chk("R8 ds bit5", 32'(ds_status_o[5]), 32'(TBL[i].d5));
                chk("R8 ds others", ds_status_o & ~32'h0820, 0);
            end
            drain();
        end

        // R3: highest machine-check source alone
        mc_src_i = MC_W'(1) << (MC_W - 1);
        @(negedge clk);
        mc_src_i = '0;
        @(negedge clk);
        chk("R3 take", 32'(take_o), 1);
        chk("R3 id", 32'(id_o), 1);
        drain();

        // R7: top alignment source, then segment bit 0
        align_src_i[ALIGN_W-1] = 1'b1;
        @(negedge clk);
        chk("R7 align id", 32'(id_o), 10);
        drain();
        seg_src_i = 2'b01;
        @(negedge clk);
        chk("R7 seg id", 32'(id_o), 12);
        chk("R8 seg bit5", 32'(ds_status_o[5]), 1);
        drain();

        // R9: branch trace needs a branch
        brtrace_en_i = 1'b1;
        @(negedge clk);
        chk("R9 no branch", 32'(take_o), 0);
        is_branch_i = 1'b1;
        @(negedge clk);
        chk("R9 branch id", 32'(id_o), 20);
        chk("R11 pulse", 32'(take_o), 1);
        @(negedge clk);
        chk("R11 pulse low", 32'(take_o), 0);
        chk("R11 sel quiet", 32'(sel_o), 0);
        drain();

        // R13: async path is one edge longer than sync path
        ee_i = 1'b1;
        extint_i = 1'b1;
        @(negedge clk);
        extint_i = 1'b0;
        chk("R13 async first edge", 32'(take_o), 0);
        @(negedge clk);
        chk("R13 async second edge", 32'(take_o), 1);
        chk("R13 async id", 32'(id_o), 16);
        // R12: acknowledge consumes the external request
        @(negedge clk);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        begin
            int seen = 0;
            repeat (5) begin
                @(negedge clk);
                if (take_o) seen++;
            end
            chk("R12 cleared by ack", 32'(seen), 0);
        end
        drain();

        // R13 sync, then R12 hold-off until ack
        fetch_fault_i = 1'b1;
        @(negedge clk);
        chk("R13 sync first edge", 32'(take_o), 1);
        chk("R13 sync id", 32'(id_o), 3);
        begin
            int seen = 0;
            repeat (5) begin
                @(negedge clk);
                if (take_o) seen++;
            end
            chk("R12 no retake in wait", 32'(seen), 0);
        end
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        chk("R12 idle after ack", 32'(take_o), 0);
        @(negedge clk);
        chk("R12 retake after ack", 32'(take_o), 1);
        chk("R12 retake id", 32'(id_o), 3);
        drain();

        // R10: masked request stays pending, taken once enabled
        ee_i = 1'b0;
        decr_i = 1'b1;
        @(negedge clk);
        decr_i = 1'b0;
        begin
            int seen = 0;
            repeat (5) begin
                @(negedge clk);
                if (take_o) seen++;
            end
            chk("R10 masked", 32'(seen), 0);
        end
        ee_i = 1'b1;
        @(negedge clk);
        chk("R10 enabled take", 32'(take_o), 1);
        chk("R10 enabled id", 32'(id_o), 18);
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule